// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

This block is a small binary counter steered by two separate count clocks instead of one clock and a direction pin. A rising edge on the up clock adds one while the down clock rests high. A rising edge on the down clock subtracts one while the up clock rests high. Both count clocks are treated as slow signals. A fast system clock samples them through synchronizers and detects their edges inside the block, so the count register itself lives in a single clock domain.

An active-high clear and an active-low load both reach the output combinationally, which mimics an asynchronous override. Each of them also sets the register at the next system-clock edge. Two active-low terminal flags follow the low phase of the matching count clock when the counter sits at its top or bottom value. Each flag can therefore serve as the count clock of a following stage.

Clocking the counter in a way whose result cannot be predicted has no effect on the count, but it sets a sticky flag. This covers two cases: both clocks rising together, or one clock rising while the other is low. The block has no streaming data path, so it has no valid/ready handshake. Every pin is a plain control or status level.

Top module: `dual_clock_counter`

## Requirements
- R1: A rising edge on `up_clk`, with `dn_clk` high and not rising, raises `count` by one. The new value appears after the third system-clock rising edge that follows the input change.
- R2: A rising edge on `dn_clk`, with `up_clk` high and not rising, lowers `count` by one, with the same latency as R1.
- R3: While `clear` is high, `count` reads 0 in the same cycle, whatever `load_n` and the count clocks do. At the next system-clock edge the register becomes 0 and `bad_clocking` is cleared.
- R4: While `load_n` is low and `clear` is low, `count` shows `load_val` combinationally. Count-clock edges that arrive during the load are ignored, and the loaded value is kept once `load_n` returns high.
- R5: `carry_n` is 0 exactly when `count` is 15 and the synchronized level of `up_clk` is low. Otherwise it is 1.
- R6: `borrow_n` is 0 exactly when `count` is 0 and the synchronized level of `dn_clk` is low. Otherwise it is 1.
- R7: Counting wraps modulo 16: up from 15 gives 0, and down from 0 gives 15.
- R8: If both clocks rise in the same sampled cycle, or one clock rises while the other is low, `count` holds and `bad_clocking` goes to 1 and stays there until a clear.
- R9: If a count clock is low during a clear or a load and stays low after it ends, its next rising edge is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples everything |
| up_clk | input | 1 | Count-up clock; counts on its rising edge |
| dn_clk | input | 1 | Count-down clock; counts on its rising edge |
| clear | input | 1 | Active-high master clear |
| load_n | input | 1 | Active-low parallel load |
| load_val | input | 4 | Value placed in the counter during a load |
| count | output | 4 | Current counter value, including clear/load override |
| carry_n | output | 1 | Active-low top-value flag following the up clock low phase |
| borrow_n | output | 1 | Active-low bottom-value flag following the down clock low phase |
| bad_clocking | output | 1 | Sticky flag for unpredictable clocking |

## Verification
The counter is driven with these patterns:
- runs of up pulses that cross 15, which separates correct wrapping from saturation;
- runs of down pulses that cross 0;
- full pulses placed inside a load, which show whether edges during an override are dropped;
- a clock held low across a clear or load and then released, which shows whether a low level is kept as an armed edge;
- the two illegal orderings, which separate a held count from a stray step.

A behavioural model that uses sampled-input queues predicts `count`, both terminal flags and the sticky flag on every clock. Each terminal flag is observed in the low phase of its clock at the boundary value and again after the clock returns high.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  localparam int DIR_UP = 0;
  localparam int DIR_DN = 1;
  localparam int N_DIRS = 2;
endpackage

// File: rtl/dcc_edge_sync.sv
module dcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_level;

  always_ff @(posedge clk) chain[0] <= async_in;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  always_ff @(posedge clk) last_level <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last_level;
endmodule

// File: rtl/dcc_step_decode.sv
module dcc_step_decode
  import dcc_pkg::*;
(
  input  logic  up_rise,
  input  logic  up_lvl,
  input  logic  dn_rise,
  input  logic  dn_lvl,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && dn_rise) begin
      step = STEP_BAD;
    end else if (up_rise) begin
      step = dn_lvl ? STEP_UP : STEP_BAD;
    end else if (dn_rise) begin
      step = up_lvl ? STEP_DOWN : STEP_BAD;
    end
  end
endmodule

// File: rtl/dcc_count_core.sv
module dcc_count_core
  import dcc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  step_e            step,
  output logic [WIDTH-1:0] cnt_q,
  output logic             bad_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_d;
  logic             bad_d;

  always_comb begin
    cnt_d = cnt_q;
    bad_d = bad_q;
    if (clear) begin
      cnt_d = '0;
      bad_d = 1'b0;
    end else if (!load_n) begin
      cnt_d = load_val;
    end else begin
      unique case (step)
        STEP_UP:   cnt_d = cnt_q + ONE;
        STEP_DOWN: cnt_d = cnt_q - ONE;
        STEP_BAD:  bad_d = 1'b1;
        default:   cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    bad_q <= bad_d;
  end
endmodule

// File: rtl/dcc_term_detect.sv
module dcc_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  assign carry_n  = ~((value == TOP_VAL) & ~up_lvl);
  assign borrow_n = ~((value == BOT_VAL) & ~dn_lvl);
endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
  import dcc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             up_clk,
  input  logic             dn_clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             bad_clocking
);
  logic [N_DIRS-1:0] raw_clk;
  logic [N_DIRS-1:0] lvl;
  logic [N_DIRS-1:0] rise;
  logic              up_lvl;
  logic              dn_lvl;
  logic              up_rise;
  logic              dn_rise;
  step_e             step;
  logic [WIDTH-1:0]  cnt_q;

  assign raw_clk[DIR_UP] = up_clk;
  assign raw_clk[DIR_DN] = dn_clk;

  generate
    for (genvar g = 0; g < N_DIRS; g++) begin : g_sync
      dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .async_in(raw_clk[g]),
        .level   (lvl[g]),
        .rise    (rise[g])
      );
    end
  endgenerate

  assign up_lvl  = lvl[DIR_UP];
  assign dn_lvl  = lvl[DIR_DN];
  assign up_rise = rise[DIR_UP];
  assign dn_rise = rise[DIR_DN];

  dcc_step_decode u_decode (
    .up_rise(up_rise),
    .up_lvl (up_lvl),
    .dn_rise(dn_rise),
    .dn_lvl (dn_lvl),
    .step   (step)
  );

  dcc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .clear   (clear),
    .load_n  (load_n),
    .load_val(load_val),
    .step    (step),
    .cnt_q   (cnt_q),
    .bad_q   (bad_clocking)
  );

  always_comb begin
    if (clear)        count = '0;
    else if (!load_n) count = load_val;
    else              count = cnt_q;
  end

  dcc_term_detect #(.WIDTH(WIDTH)) u_term (
    .value   (count),
    .up_lvl  (up_lvl),
    .dn_lvl  (dn_lvl),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear,
  input logic             load_n,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] cnt_q,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             bad_clocking,
  input logic             up_rise,
  input logic             up_lvl,
  input logic             dn_rise,
  input logic             dn_lvl
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOPV = '1;

  // R3
  clear_zero_chk: assert property (@(posedge clk) clear |-> count == '0);

  // R4
  load_show_chk: assert property (@(posedge clk) disable iff (clear)
    !load_n |-> count == load_val);

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && up_rise && !dn_rise && dn_lvl) |=> cnt_q == $past(cnt_q) + ONE);

  // R2
  down_step_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && dn_rise && !up_rise && up_lvl) |=> cnt_q == $past(cnt_q) - ONE);

  // R8
  bad_hold_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && ((up_rise && dn_rise) || (up_rise && !dn_lvl) || (dn_rise && !up_lvl)))
    |=> ($stable(cnt_q) && bad_clocking));

  // R8
  bad_sticky_chk: assert property (@(posedge clk) disable iff (clear)
    bad_clocking |=> bad_clocking);

  // R5
  carry_chk: assert property (@(posedge clk) disable iff (clear)
    !carry_n |-> (count == TOPV && !up_lvl));

  // R6
  borrow_chk: assert property (@(posedge clk) disable iff (clear)
    !borrow_n |-> (count == '0 && !dn_lvl));
endmodule

bind dual_clock_counter dcc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .clear       (clear),
  .load_n      (load_n),
  .load_val    (load_val),
  .count       (count),
  .cnt_q       (cnt_q),
  .carry_n     (carry_n),
  .borrow_n    (borrow_n),
  .bad_clocking(bad_clocking),
  .up_rise     (up_rise),
  .up_lvl      (up_lvl),
  .dn_rise     (dn_rise),
  .dn_lvl      (dn_lvl)
);

// File: tb/dual_clock_counter_bench.sv
module dual_clock_counter_bench;
  logic       clk = 1'b0;
  logic       up_clk = 1'b1;
  logic       dn_clk = 1'b1;
  logic       clear = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count;
  logic       carry_n;
  logic       borrow_n;
  logic       bad_clocking;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dual_clock_counter u_dual_clock_counter (
    .clk(clk), .up_clk(up_clk), .dn_clk(dn_clk), .clear(clear),
    .load_n(load_n), .load_val(load_val), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n), .bad_clocking(bad_clocking)
  );

  // behavioural reference model
  bit uq[$];
  bit dq[$];
  int m_cnt = 0;
  bit m_bad = 0;
  bit model_on = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      uq.push_back(1'b1);
      dq.push_back(1'b1);
    end
  end

  always @(posedge clk) begin
    bit ur, dr, ul, dl;
    int ev;
    ur = uq[1] && !uq[2];
    dr = dq[1] && !dq[2];
    ul = uq[1];
    dl = dq[1];
    if (clear) begin
      m_cnt = 0;
      m_bad = 0;
    end else if (!load_n) begin
      m_cnt = load_val;
    end else if (ur || dr) begin
      if (ur && !dr && dl)      m_cnt = (m_cnt + 1) % 16;
      else if (dr && !ur && ul) m_cnt = (m_cnt + 15) % 16;
      else                      m_bad = 1;
    end
    uq.push_front(up_clk); void'(uq.pop_back());
    dq.push_front(dn_clk); void'(dq.pop_back());
    #1;
    if (model_on) begin
      ev = clear ? 0 : (!load_n ? int'(load_val) : m_cnt);
      check(clear ? "R3 count" : (!load_n ? "R4 count" : "R1/R2 count"), count, ev);
      check("R5 carry_n", carry_n, (ev == 15 && !uq[1]) ? 0 : 1);
      check("R6 borrow_n", borrow_n, (ev == 0 && !dq[1]) ? 0 : 1);
      check("R8 bad_clocking", bad_clocking, m_bad);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    @(negedge clk); up_clk = 1'b0; idle(4); up_clk = 1'b1; idle(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn_clk = 1'b0; idle(4); dn_clk = 1'b1; idle(4);
  endtask

  task automatic do_load(int v, int n);
    @(negedge clk); load_val = 4'(v); load_n = 1'b0; idle(n); load_n = 1'b1; idle(1);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(6);
    model_on = 1;
    check("R3 reset count", count, 0);
    @(negedge clk); clear = 1'b0; idle(2);
    check("R3 after clear", count, 0);
    check("R6 borrow idle high", borrow_n, 1);

    for (int i = 0; i < 3; i++) pulse_up();
    check("R1 three ups", count, 3);
    for (int i = 0; i < 2; i++) pulse_dn();
    check("R2 two downs", count, 1);

    // load with a full up pulse inside it
    @(negedge clk); load_val = 4'd14; load_n = 1'b0; idle(2);
    check("R4 load visible", count, 14);
    up_clk = 1'b0; idle(4); up_clk = 1'b1; idle(5);
    load_n = 1'b1; idle(3);
    check("R4 edge in load ignored", count, 14);

    pulse_up();
    check("R1 to top", count, 15);
    @(negedge clk); up_clk = 1'b0; idle(4);
    check("R5 carry low at top", carry_n, 0);
    up_clk = 1'b1; idle(4);
    check("R7 wrap up", count, 0);
    check("R5 carry high after", carry_n, 1);

    @(negedge clk); dn_clk = 1'b0; idle(4);
    check("R6 borrow low at zero", borrow_n, 0);
    dn_clk = 1'b1; idle(4);
    check("R7 wrap down", count, 15);
    check("R6 borrow high after", borrow_n, 1);

    // R9: clock low across a load
    @(negedge clk); dn_clk = 1'b0; idle(4);
    do_load(7, 3); idle(3);
    dn_clk = 1'b1; idle(4);
    check("R9 edge after load", count, 6);

    // R9: clock low across a clear
    @(negedge clk); up_clk = 1'b0; idle(4);
    clear = 1'b1; idle(3); clear = 1'b0; idle(3);
    up_clk = 1'b1; idle(4);
    check("R9 edge after clear", count, 1);

    // R8: up rises while down low
    @(negedge clk); dn_clk = 1'b0; up_clk = 1'b0; idle(4);
    up_clk = 1'b1; idle(4);
    check("R8 hold on bad edge", count, 1);
    check("R8 flag set", bad_clocking, 1);
    dn_clk = 1'b1; idle(4);
    check("R2 legal down after", count, 0);
    check("R8 flag sticky", bad_clocking, 1);

    @(negedge clk); clear = 1'b1; idle(2); clear = 1'b0; idle(2);
    check("R3 flag cleared", bad_clocking, 0);

    // R8: both rise together
    for (int i = 0; i < 4; i++) pulse_up();
    @(negedge clk); up_clk = 1'b0; dn_clk = 1'b0; idle(4);
    up_clk = 1'b1; dn_clk = 1'b1; idle(4);
    check("R8 both rise hold", count, 4);
    check("R8 both rise flag", bad_clocking, 1);

    // R3: clear overrides load
    @(negedge clk); load_val = 4'd9; load_n = 1'b0; clear = 1'b1; idle(1);
    check("R3 clear beats load", count, 0);
    clear = 1'b0; load_n = 1'b1; idle(2);
    check("R3 reg zero", count, 0);

    for (int i = 0; i < 18; i++) pulse_dn();
    check("R7 long down run", count, 14);
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule